// File: doc/BRIEF.md
# Disciplined Time-of-Day Counter with Holdover

This block keeps a 64-bit nanosecond time-of-day value that moves forward on every system clock cycle by a fixed-point rate word. The rate word has 32 fractional nanosecond bits, so trims finer than one nanosecond per cycle add up in a fractional accumulator. An external servo measures the offset between a reference and this counter. It presents that signed offset with a one-cycle strobe, and it drives a flag that says whether a reference is present. The block then corrects itself in one of two ways. An offset whose magnitude is above a programmable threshold is removed at once by a phase step. A smaller offset drives a proportional-integral loop, which retunes only the rate and leaves the time value continuous.

A small controller tracks the discipline state, reported as free-running, acquiring, locked or holdover. When the reference is gone and offsets stop arriving, the block enters holdover. In holdover the learned integral rate is kept and the proportional part is dropped. When the reference returns, the block does not step time. The returning offset is loaded as a pending correction, and that correction is bled into the counter at no more than one nanosecond per slew interval.

Top module: `time_servo_top`

## Requirements
- R1: While reset is held, `time_ns` is 0, `servo_state` is 0 (free-running) and `freq_word` equals `base_inc`.
- R2: With no correction active, `time_ns` advances each cycle by `freq_word`, read as unsigned nanoseconds with 32 fractional bits. A rate of exactly 4.0 ns gives 4·N over N cycles.
- R3: An accepted offset whose magnitude exceeds `step_thresh` adds the signed offset to `time_ns` in that same update and leaves `freq_word` unchanged.
- R4: An accepted offset with magnitude at most `step_thresh` sets the proportional term to offset<<`kp_shift` and adds offset<<`ki_shift` to the integral term. The rate becomes `freq_word = base_inc + proportional + integral`, in units of 2^-32 ns, clipped to the port range.
- R5: The integral term saturates at ±`integ_limit`.
- R6: State codes are 0 free-running, 1 acquiring, 2 locked and 3 holdover. Any accepted offset in state 0 moves the block to 1. `LOCK_COUNT` consecutive accepted offsets with magnitude at most `lock_window` move it from 1 to 2. An offset outside the window in state 1 or 2 leaves the block in, or returns it to, 1.
- R7: In state 1 or 2 the block enters state 3 once `HOLD_TIMEOUT` cycles have passed with no offset strobe and `ref_present` is low. While `ref_present` is high, no holdover is entered.
- R8: In holdover the proportional term is zero and the integral term is frozen, so `freq_word = base_inc + integral`.
- R9: In holdover, an offset strobe with `ref_present` high moves the block to state 1 without a step. That offset becomes a pending correction, which is applied as ±1 ns once every `SLEW_INTERVAL` cycles until it is used up.
- R10: While a pending correction remains, offset strobes are ignored: no step, no rate change, no state change.
- R11: Apart from a negative phase step or a negative pending correction, `time_ns` never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_inc | input | INC_W | Nominal rate word, ns with FRAC_W fractional bits |
| off_valid | input | 1 | One-cycle strobe qualifying `off_ns` |
| off_ns | input | OFF_W | Signed offset, reference minus local, in ns |
| ref_present | input | 1 | Reference currently available |
| kp_shift | input | SH_W | Proportional gain as a left shift |
| ki_shift | input | SH_W | Integral gain as a left shift |
| integ_limit | input | INC_W | Magnitude limit of the integral term |
| step_thresh | input | OFF_W | Offset magnitude above which a phase step is taken |
| lock_window | input | OFF_W | Offset magnitude counted as in lock |
| time_ns | output | TIME_W | Integer nanoseconds of time of day |
| freq_word | output | INC_W | Rate word currently applied |
| servo_state | output | 2 | Discipline state code |

## Verification
The bench builds the block with `LOCK_COUNT` = 3, `HOLD_TIMEOUT` = 50 and `SLEW_INTERVAL` = 4. With these values, lock acquisition, the holdover timeout and a full six-nanosecond exit slew all finish in a few dozen cycles, and every cycle of the slew can be inspected. The gain shifts and the integral limit are changed partway through the run. The integral term is pinned at exactly 1.0 ns per cycle, so the holdover rate is an integer and per-cycle time deltas can be predicted exactly. A stray offset sent during the slew shows whether strobes are really ignored.

// File: rtl/tsv_pkg.sv
package tsv_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_LOCK = 2'd2,
        ST_HOLD = 2'd3
    } srv_state_e;
endpackage

// File: rtl/tsv_state_ctrl.sv
module tsv_state_ctrl
    import tsv_pkg::*;
#(
    parameter int OFF_W        = 32,
    parameter int LOCK_COUNT   = 8,
    parameter int HOLD_TIMEOUT = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             off_valid,
    input  logic [OFF_W-1:0] off_ns,
    input  logic             ref_present,
    input  logic [OFF_W-1:0] step_thresh,
    input  logic [OFF_W-1:0] lock_window,
    input  logic             ramp_busy,
    output logic             step_o,
    output logic             pi_o,
    output logic             load_o,
    output srv_state_e       state_o
);
    localparam int LC_W = $clog2(LOCK_COUNT + 1);
    localparam int TO_W = $clog2(HOLD_TIMEOUT + 1);
    localparam logic [LC_W-1:0] LC_LAST = LC_W'(LOCK_COUNT - 1);
    localparam logic [TO_W-1:0] TO_MAX  = TO_W'(HOLD_TIMEOUT);

    typedef struct packed {
        srv_state_e      st;
        logic [LC_W-1:0] lcnt;
        logic [TO_W-1:0] tcnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [OFF_W-1:0] mag;
    logic big, inwin, accept;

    always_comb begin
        mag    = off_ns[OFF_W-1] ? (~off_ns + 1'b1) : off_ns;
        big    = mag > step_thresh;
        inwin  = mag <= lock_window;
        accept = off_valid && !ramp_busy;
        ctl_d  = ctl_q;
        step_o = 1'b0;
        pi_o   = 1'b0;
        load_o = 1'b0;

        if (off_valid)
            ctl_d.tcnt = '0;
        else if (ctl_q.tcnt != TO_MAX)
            ctl_d.tcnt = ctl_q.tcnt + 1'b1;

        case (ctl_q.st)
            ST_FREE: begin
                if (accept) begin
                    ctl_d.st   = ST_ACQ;
                    ctl_d.lcnt = '0;
                    step_o     = big;
                    pi_o       = !big;
                end
            end
            ST_ACQ, ST_LOCK: begin
                if (accept) begin
                    if (big) begin
                        step_o     = 1'b1;
                        ctl_d.st   = ST_ACQ;
                        ctl_d.lcnt = '0;
                    end else begin
                        pi_o = 1'b1;
                        if (!inwin) begin
                            ctl_d.st   = ST_ACQ;
                            ctl_d.lcnt = '0;
                        end else if (ctl_q.st == ST_ACQ) begin
                            if (ctl_q.lcnt == LC_LAST) begin
                                ctl_d.st   = ST_LOCK;
                                ctl_d.lcnt = '0;
                            end else begin
                                ctl_d.lcnt = ctl_q.lcnt + 1'b1;
                            end
                        end
                    end
                end else if (ctl_q.tcnt == TO_MAX && !ref_present) begin
                    ctl_d.st   = ST_HOLD;
                    ctl_d.lcnt = '0;
                end
            end
            ST_HOLD: begin
                if (accept && ref_present) begin
                    load_o     = 1'b1;
                    ctl_d.st   = ST_ACQ;
                    ctl_d.lcnt = '0;
                end
            end
            default: ctl_d.st = ST_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign state_o = ctl_q.st;

    // R6
    free_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_FREE) |=> (ctl_q.st == ST_FREE || ctl_q.st == ST_ACQ));

    // R7
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_HOLD && !(off_valid && ref_present)) |=> (ctl_q.st == ST_HOLD));

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_busy |-> (!step_o && !pi_o && !load_o));
endmodule

// File: rtl/tsv_pi_loop.sv
module tsv_pi_loop #(
    parameter int OFF_W = 32,
    parameter int INC_W = 48,
    parameter int SH_W  = 6,
    parameter int ACC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pi_i,
    input  logic             hold_i,
    input  logic [OFF_W-1:0] off_ns,
    input  logic [SH_W-1:0]  kp_shift,
    input  logic [SH_W-1:0]  ki_shift,
    input  logic [INC_W-1:0] integ_limit,
    input  logic [INC_W-1:0] base_inc,
    output logic [INC_W-1:0] freq_word
);
    typedef struct packed {
        logic signed [ACC_W-1:0] prop;
        logic signed [ACC_W-1:0] integ;
    } pi_t;

    pi_t pi_d, pi_q;
    logic signed [ACC_W-1:0] off_x, lim, isum, base_x, fsum, fmax;

    always_comb begin
        off_x  = {{(ACC_W-OFF_W){off_ns[OFF_W-1]}}, off_ns};
        lim    = {{(ACC_W-INC_W){1'b0}}, integ_limit};
        base_x = {{(ACC_W-INC_W){1'b0}}, base_inc};
        fmax   = {{(ACC_W-INC_W){1'b0}}, {INC_W{1'b1}}};
        isum   = pi_q.integ + (off_x <<< ki_shift);
        pi_d   = pi_q;
        if (pi_i) begin
            pi_d.prop = off_x <<< kp_shift;
            if (isum > lim)       pi_d.integ = lim;
            else if (isum < -lim) pi_d.integ = -lim;
            else                  pi_d.integ = isum;
        end
        if (hold_i) pi_d.prop = '0;

        fsum = base_x + pi_q.prop + pi_q.integ;
        if (fsum[ACC_W-1])   freq_word = '0;
        else if (fsum > fmax) freq_word = {INC_W{1'b1}};
        else                  freq_word = fsum[INC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pi_q <= '0;
        else        pi_q <= pi_d;
    end

    // R5
    integ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pi_i |=> (pi_q.integ <= $past(lim) && pi_q.integ >= -$past(lim)));

    // R8
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !pi_i) |=> $stable(pi_q.integ));
endmodule

// File: rtl/tsv_phase_acc.sv
module tsv_phase_acc #(
    parameter int TIME_W        = 64,
    parameter int FRAC_W        = 32,
    parameter int INC_W         = 48,
    parameter int OFF_W         = 32,
    parameter int SLEW_INTERVAL = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              load_i,
    input  logic [OFF_W-1:0]  off_ns,
    input  logic [INC_W-1:0]  freq_word,
    output logic [TIME_W-1:0] time_ns,
    output logic              ramp_busy
);
    localparam int PH_W = TIME_W + FRAC_W;
    localparam int SC_W = $clog2(SLEW_INTERVAL + 1);
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(SLEW_INTERVAL - 1);

    typedef struct packed {
        logic [PH_W-1:0]  ph;
        logic [OFF_W-1:0] pend;
        logic [SC_W-1:0]  sc;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [TIME_W-1:0] adj;
    logic [OFF_W-1:0]  pend_mag;
    logic              tick;

    always_comb begin
        acc_d = acc_q;
        adj   = '0;
        tick  = (acc_q.sc == SC_LAST);
        acc_d.sc = tick ? '0 : acc_q.sc + 1'b1;

        if (step_i) begin
            adj = {{(TIME_W-OFF_W){off_ns[OFF_W-1]}}, off_ns};
        end else if (tick && acc_q.pend != '0) begin
            if (acc_q.pend[OFF_W-1]) begin
                adj        = {TIME_W{1'b1}};
                acc_d.pend = acc_q.pend + 1'b1;
            end else begin
                adj        = TIME_W'(1);
                acc_d.pend = acc_q.pend - 1'b1;
            end
        end
        if (load_i) acc_d.pend = off_ns;

        acc_d.ph = acc_q.ph + {{(PH_W-INC_W){1'b0}}, freq_word}
                            + {adj, {FRAC_W{1'b0}}};
        pend_mag = acc_q.pend[OFF_W-1] ? (~acc_q.pend + 1'b1) : acc_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign time_ns   = acc_q.ph[PH_W-1:FRAC_W];
    assign ramp_busy = (acc_q.pend != '0);

    // R11
    monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !acc_q.pend[OFF_W-1]) |=> (time_ns >= $past(time_ns)));

    // R9
    pend_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (pend_mag <= $past(pend_mag)));

    // R9
    pend_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($past(pend_mag) - pend_mag <= 1));
endmodule

// File: rtl/time_servo_top.sv
module time_servo_top
    import tsv_pkg::*;
#(
    parameter int TIME_W        = 64,
    parameter int FRAC_W        = 32,
    parameter int INC_W         = 48,
    parameter int OFF_W         = 32,
    parameter int SH_W          = 6,
    parameter int ACC_W         = 64,
    parameter int LOCK_COUNT    = 8,
    parameter int HOLD_TIMEOUT  = 1000000,
    parameter int SLEW_INTERVAL = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INC_W-1:0]  base_inc,
    input  logic              off_valid,
    input  logic [OFF_W-1:0]  off_ns,
    input  logic              ref_present,
    input  logic [SH_W-1:0]   kp_shift,
    input  logic [SH_W-1:0]   ki_shift,
    input  logic [INC_W-1:0]  integ_limit,
    input  logic [OFF_W-1:0]  step_thresh,
    input  logic [OFF_W-1:0]  lock_window,
    output logic [TIME_W-1:0] time_ns,
    output logic [INC_W-1:0]  freq_word,
    output logic [1:0]        servo_state
);
    logic       do_step, do_pi, do_load, busy;
    srv_state_e st;

    tsv_state_ctrl #(
        .OFF_W(OFF_W), .LOCK_COUNT(LOCK_COUNT), .HOLD_TIMEOUT(HOLD_TIMEOUT)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .off_valid(off_valid), .off_ns(off_ns),
        .ref_present(ref_present), .step_thresh(step_thresh),
        .lock_window(lock_window), .ramp_busy(busy),
        .step_o(do_step), .pi_o(do_pi), .load_o(do_load), .state_o(st)
    );

    tsv_pi_loop #(
        .OFF_W(OFF_W), .INC_W(INC_W), .SH_W(SH_W), .ACC_W(ACC_W)
    ) u_pi (
        .clk(clk), .rst_n(rst_n), .pi_i(do_pi), .hold_i(st == ST_HOLD),
        .off_ns(off_ns), .kp_shift(kp_shift), .ki_shift(ki_shift),
        .integ_limit(integ_limit), .base_inc(base_inc), .freq_word(freq_word)
    );

    tsv_phase_acc #(
        .TIME_W(TIME_W), .FRAC_W(FRAC_W), .INC_W(INC_W), .OFF_W(OFF_W),
        .SLEW_INTERVAL(SLEW_INTERVAL)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .step_i(do_step), .load_i(do_load),
        .off_ns(off_ns), .freq_word(freq_word), .time_ns(time_ns),
        .ramp_busy(busy)
    );

    assign servo_state = st;

    // R3
    step_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && !do_pi) |=> $stable(freq_word));
endmodule

// File: tb/sim_time_servo_top.sv
`timescale 1ns/1ps
module sim_time_servo_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] base_inc = 48'h4_0000_0000;
    logic        off_valid = 1'b0;
    logic [31:0] off_ns = '0;
    logic        ref_present = 1'b1;
    logic [5:0]  kp_shift = 6'd20;
    logic [5:0]  ki_shift = 6'd16;
    logic [47:0] integ_limit = 48'd25 << 16;
    logic [31:0] step_thresh = 32'd500;
    logic [31:0] lock_window = 32'd20;
    logic [63:0] time_ns;
    logic [47:0] freq_word;
    logic [1:0]  servo_state;

    always #2.0 clk = ~clk;

    time_servo_top #(
        .LOCK_COUNT(3), .HOLD_TIMEOUT(50), .SLEW_INTERVAL(4)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .base_inc(base_inc), .off_valid(off_valid),
        .off_ns(off_ns), .ref_present(ref_present), .kp_shift(kp_shift),
        .ki_shift(ki_shift), .integ_limit(integ_limit), .step_thresh(step_thresh),
        .lock_window(lock_window), .time_ns(time_ns), .freq_word(freq_word),
        .servo_state(servo_state)
    );

    typedef enum int {K_TIME, K_FREQ, K_STATE, K_DELTA, K_VALUE} kind_e;
    typedef struct {
        string       tag;
        kind_e       kind;
        logic [63:0] exp;
        logic [63:0] aux;
    } item_t;

    item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic expect_item(string tag, kind_e k, logic [63:0] e, logic [63:0] a);
        item_t it;
        it.tag = tag; it.kind = k; it.exp = e; it.aux = a;
        sb_q.push_back(it);
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
        #0.1;
    endtask

    task automatic send(logic [31:0] v);
        off_ns = v;
        off_valid = 1'b1;
        cyc(1);
        off_valid = 1'b0;
    endtask

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            #0.2;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [63:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_TIME:  act = time_ns;
                    K_FREQ:  act = {16'd0, freq_word};
                    K_STATE: act = {62'd0, servo_state};
                    K_DELTA: act = time_ns - it.aux;
                    default: act = it.aux;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 4.0);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] t0, prev, d;
        longint unsigned base;
        int n6, dmax, dmin;
        base = 64'h4_0000_0000;

        // R1: reset values
        cyc(3);
        expect_item("R1", K_TIME, 64'd0, 64'd0);
        expect_item("R1", K_STATE, 64'd0, 64'd0);
        expect_item("R1", K_FREQ, base, 64'd0);
        cyc(1);
        rst_n = 1'b1;
        cyc(2);

        // R2: plain advance at 4.0 ns per cycle
        t0 = time_ns;
        cyc(20);
        expect_item("R2", K_DELTA, 64'd80, t0);

        // R3: large offset stepped in, rate untouched
        t0 = time_ns;
        send(32'd1000);
        cyc(9);
        expect_item("R3", K_DELTA, 64'd1040, t0);
        expect_item("R3", K_FREQ, base, 64'd0);
        expect_item("R6", K_STATE, 64'd1, 64'd0);

        // R4 / R6: small offsets through PI, lock after three in window
        send(32'd10);
        expect_item("R4", K_FREQ, base + (64'd10 << 20) + (64'd10 << 16), 64'd0);
        expect_item("R6", K_STATE, 64'd1, 64'd0);
        cyc(2);
        send(32'd10);
        expect_item("R4", K_FREQ, base + (64'd10 << 20) + (64'd20 << 16), 64'd0);
        cyc(2);
        send(32'd10);
        expect_item("R5", K_FREQ, base + (64'd10 << 20) + (64'd25 << 16), 64'd0);
        expect_item("R6", K_STATE, 64'd2, 64'd0);
        cyc(2);

        // R6 / R4: out-of-window offset drops lock, negative correction
        send(-32'sd40);
        expect_item("R4", K_FREQ, base - (64'd40 << 20) - (64'd15 << 16), 64'd0);
        expect_item("R6", K_STATE, 64'd1, 64'd0);
        cyc(2);
        send(-32'sd40);
        expect_item("R5", K_FREQ, base - (64'd40 << 20) - (64'd25 << 16), 64'd0);
        cyc(2);

        // R5: integral pinned at exactly 1.0 ns/cycle
        integ_limit = 48'h1_0000_0000;
        ki_shift = 6'd29;
        kp_shift = 6'd0;
        send(32'd10);
        expect_item("R5", K_FREQ, base + 64'd10 + 64'h1_0000_0000, 64'd0);

        // R7: timeout with reference present keeps state
        cyc(70);
        expect_item("R7", K_STATE, 64'd1, 64'd0);

        // R7 / R8: reference lost -> holdover at base + integral
        ref_present = 1'b0;
        cyc(3);
        expect_item("R7", K_STATE, 64'd3, 64'd0);
        expect_item("R8", K_FREQ, 64'h5_0000_0000, 64'd0);
        t0 = time_ns;
        cyc(10);
        expect_item("R8", K_DELTA, 64'd50, t0);

        // R9 / R10 / R11: return of reference, slewed exit
        ref_present = 1'b1;
        cyc(1);
        t0 = time_ns;
        prev = t0;
        n6 = 0; dmax = 0; dmin = 1000;
        for (int i = 0; i < 40; i++) begin
            if (i == 0) begin off_ns = 32'd6; off_valid = 1'b1; end
            if (i == 5) begin off_ns = 32'd3; off_valid = 1'b1; end
            cyc(1);
            off_valid = 1'b0;
            d = time_ns - prev;
            prev = time_ns;
            if (d == 64'd6) n6++;
            if (int'(d) > dmax) dmax = int'(d);
            if (int'(d) < dmin) dmin = int'(d);
        end
        expect_item("R9", K_DELTA, 64'd206, t0);
        expect_item("R9", K_VALUE, 64'd6, 64'(n6));
        expect_item("R9", K_STATE, 64'd1, 64'd0);
        expect_item("R10", K_FREQ, 64'h5_0000_0000, 64'd0);
        expect_item("R11", K_VALUE, 64'd1, 64'(dmax <= 6 && dmin >= 5));

        // R4: normal discipline resumes after the slew
        send(32'd10);
        expect_item("R4", K_FREQ, base + 64'd10 + 64'h1_0000_0000, 64'd0);

        cyc(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule